// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets software read, program and erase words of an on-chip flash through six word-indexed registers. Software loads a command code, a word address and (for programming) a data word, then writes 1 to a start bit. Before anything reaches the flash, the block checks the operation:

- the command code must be known;
- the address must be word aligned and fall inside a defined region;
- write protection must allow the access from the region the core booted from;
- no brown-out may be signalled at that moment.

A refused operation never reaches the flash. It raises a sticky fail flag that software clears by writing 1 to it. An accepted operation is issued on a request/acknowledge flash port, and the start bit drops when the flash acknowledges.

The address space holds three regions: an application region starting at zero, a loader region and a configuration region. The upper part of the application region, from a data base address upward, is data flash. The data base address is loaded from a configuration input on every reset. A boot-select status bit records which region the core runs from. Only a power-on reset sets it, to the inverse of a configuration boot bit.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the control, start, command, address and data registers read 0, except the boot-select bit. `flReq` is 0. Register index map on `regIdx`: 0 control, 1 start, 2 command, 3 address, 4 data, 5 data base. Any other index reads 0.
- R2: Writing 1 to start bit 0 (index 1) while enable (control bit 0) is 0 does nothing. The start bit stays 0 and no flash request is made.
- R3: An accepted start sets the start bit to 1 on the next edge. After one check cycle, `flReq` rises and stays high, with address, data and operation steady, until the edge where `flAck` is sampled high. On that edge `flReq` and the start bit both return to 0.
- R4: For a read, the data register holds `flRdData` from the acknowledge edge onward.
- R5: An operation is refused if any of these holds: the code is unknown, address bits [1:0] are not 00, the address is outside all regions, or `bodEvent` is high in the check cycle. A refusal sets the fail flag (control bit 6), clears the start bit on the edge after the check cycle, and never raises `flReq`.
- R6: Control bit 1 selects the boot region (1 means loader). Running from the application region, a program or erase below the data base address is refused unless the self-write enable (control bit 3) is set. Running from the loader, a program or erase of the loader region is always refused.
- R7: A program or erase of the loader region is accepted only when running from the application region with the loader update enable (control bit 5) set.
- R8: Any operation, including a read, on the configuration region is refused unless the configuration update enable (control bit 4) is set.
- R9: A program or erase at or above the data base address inside the application region is accepted without the self-write enable.
- R10: Writing 1 to control bit 6 clears the fail flag. Writing 0 leaves it set. A refusal in the same cycle as the clear wins.
- R11: While the start bit is 1, writes to the command, address and data registers are ignored.
- R12: A non-power-on reset keeps the boot-select bit. Every reset loads the data base register from `cfgDataBase`, and writes to that register are ignored. A power-on reset sets boot-select to the inverse of `cfgBootBit`.
- R13: Command codes are 0x00 read, 0x21 program and 0x22 page erase. They appear on `flOp` as 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| porN | input | 1 | Active-low synchronous power-on reset |
| cfgBootBit | input | 1 | Configuration boot bit; boot-select takes its inverse at power-on |
| cfgDataBase | input | 32 | Configuration data flash base address, loaded on reset |
| bodEvent | input | 1 | Brown-out indication |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regIdx` (combinational) |
| flReq | output | 1 | Flash operation request |
| flOp | output | 2 | Flash operation: 0 read, 1 program, 2 erase |
| flAddr | output | 32 | Flash word address |
| flWrData | output | 32 | Flash program data |
| flAck | input | 1 | Flash acknowledge, ends the request |
| flRdData | input | 32 | Flash read data, valid with `flAck` |

## Verification
The assertions assume the flash raises `flAck` only while `flReq` is high, and for a single cycle per request. They also assume software leaves `regIdx` pointing at a defined register whenever it writes. The bench's flash responder counts request cycles and drives one acknowledge pulse after a fixed latency, dropping it on the following cycle. All register writes use indices 0 to 5. The brown-out input is raised only around triggers meant to be refused, so every other request completes normally.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_TRIG = 3'd1;
  localparam logic [2:0] IDX_CMD  = 3'd2;
  localparam logic [2:0] IDX_ADDR = 3'd3;
  localparam logic [2:0] IDX_DATA = 3'd4;
  localparam logic [2:0] IDX_BASE = 3'd5;

  localparam int CB_ISP  = 0;
  localparam int CB_BOOT = 1;
  localparam int CB_APPW = 3;
  localparam int CB_CFGU = 4;
  localparam int CB_LDRU = 5;
  localparam int CB_FAIL = 6;

  localparam int CMD_W = 6;
  localparam logic [CMD_W-1:0] CMD_READ  = 6'h00;
  localparam logic [CMD_W-1:0] CMD_PROG  = 6'h21;
  localparam logic [CMD_W-1:0] CMD_ERASE = 6'h22;

  typedef enum logic [1:0] {
    FOP_READ  = 2'd0,
    FOP_PROG  = 2'd1,
    FOP_ERASE = 2'd2
  } fl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ISSUE = 2'd2
  } fsm_e;

  typedef struct packed {
    logic trigClr;
    logic failSet;
    logic rdCapture;
  } ctl_strobe_t;

  typedef struct packed {
    logic bootSel;
    logic appWrEn;
    logic cfgUpdEn;
    logic ldrUpdEn;
  } prot_bits_t;

endpackage

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import flash_prog_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 porN,
  input  logic                 cfgBootBit,
  input  logic [AW-1:0]        cfgDataBase,
  input  logic                 regWrEn,
  input  logic [2:0]           regIdx,
  input  logic [DW-1:0]        regWrData,
  output logic [DW-1:0]        regRdData,
  input  ctl_strobe_t          strobe,
  input  logic [DW-1:0]        flRdData,
  output prot_bits_t           protBits,
  output logic                 trigBusy,
  output logic                 trigStart,
  output logic [CMD_W-1:0]     cmdCode,
  output logic [AW-1:0]        opAddr,
  output logic [DW-1:0]        opData,
  output logic [AW-1:0]        dataBase
);

  logic ispEn, bootSel, appWrEn, cfgUpdEn, ldrUpdEn, failFlag;
  logic wrCtrl, wrTrig, wrCmd, wrAddr, wrData;

  assign wrCtrl = regWrEn && (regIdx == IDX_CTRL);
  assign wrTrig = regWrEn && (regIdx == IDX_TRIG);
  assign wrCmd  = regWrEn && (regIdx == IDX_CMD);
  assign wrAddr = regWrEn && (regIdx == IDX_ADDR);
  assign wrData = regWrEn && (regIdx == IDX_DATA);

  assign trigStart = wrTrig && regWrData[0] && ispEn && !trigBusy;

  // boot select survives every reset except power-on
  always_ff @(posedge clk) begin
    if (!porN)       bootSel <= ~cfgBootBit;
    else if (wrCtrl) bootSel <= regWrData[CB_BOOT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ispEn    <= 1'b0;
      appWrEn  <= 1'b0;
      cfgUpdEn <= 1'b0;
      ldrUpdEn <= 1'b0;
      failFlag <= 1'b0;
      trigBusy <= 1'b0;
      cmdCode  <= '0;
      opAddr   <= '0;
      opData   <= '0;
      dataBase <= cfgDataBase;
    end else begin
      if (wrCtrl) begin
        ispEn    <= regWrData[CB_ISP];
        appWrEn  <= regWrData[CB_APPW];
        cfgUpdEn <= regWrData[CB_CFGU];
        ldrUpdEn <= regWrData[CB_LDRU];
      end
      if (strobe.failSet)                      failFlag <= 1'b1;
      else if (wrCtrl && regWrData[CB_FAIL])   failFlag <= 1'b0;

      if (trigStart)           trigBusy <= 1'b1;
      else if (strobe.trigClr) trigBusy <= 1'b0;

      if (!trigBusy) begin
        if (wrCmd)  cmdCode <= regWrData[CMD_W-1:0];
        if (wrAddr) opAddr  <= regWrData[AW-1:0];
        if (wrData) opData  <= regWrData;
      end
      if (strobe.rdCapture) opData <= flRdData;
    end
  end

  assign protBits = '{bootSel: bootSel, appWrEn: appWrEn,
                      cfgUpdEn: cfgUpdEn, ldrUpdEn: ldrUpdEn};

  always_comb begin
    regRdData = '0;
    unique case (regIdx)
      IDX_CTRL: begin
        regRdData[CB_ISP]  = ispEn;
        regRdData[CB_BOOT] = bootSel;
        regRdData[CB_APPW] = appWrEn;
        regRdData[CB_CFGU] = cfgUpdEn;
        regRdData[CB_LDRU] = ldrUpdEn;
        regRdData[CB_FAIL] = failFlag;
      end
      IDX_TRIG: regRdData[0] = trigBusy;
      IDX_CMD:  regRdData[CMD_W-1:0] = cmdCode;
      IDX_ADDR: regRdData[AW-1:0] = opAddr;
      IDX_DATA: regRdData = opData;
      IDX_BASE: regRdData[AW-1:0] = dataBase;
      default:  regRdData = '0;
    endcase
  end

  // R2: a start written while disabled leaves the block idle
  p_ignore_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrTrig && regWrData[0] && !ispEn && !trigBusy) |=> !trigBusy);

  // R10: write-one clears the flag unless a refusal lands in the same cycle
  p_fail_w1c_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[CB_FAIL] && !strobe.failSet) |=> !failFlag);

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !(wrCtrl && regWrData[CB_FAIL])) |=> failFlag);

  // R11: operands frozen while busy
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (trigBusy && wrAddr) |=> $stable(opAddr));

  // R12: base address never changes outside reset
  p_base_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(dataBase));

endmodule

// File: rtl/fpc_control.sv
module fpc_control
  import flash_prog_pkg::*;
#(
  parameter int AW = 32,
  parameter int unsigned APP_SIZE = 32'h0000_8000,
  parameter int unsigned LDR_BASE = 32'h0010_0000,
  parameter int unsigned LDR_SIZE = 32'h0000_1000,
  parameter int unsigned CFG_BASE = 32'h0030_0000,
  parameter int unsigned CFG_SIZE = 32'h0000_0010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigStart,
  input  logic             trigBusy,
  input  prot_bits_t       protBits,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic [AW-1:0]    opAddr,
  input  logic [AW-1:0]    dataBase,
  input  logic             bodEvent,
  input  logic             flAck,
  output ctl_strobe_t      strobe,
  output logic             flReq,
  output logic [1:0]       flOp
);

  localparam logic [AW-1:0] APP_END = AW'(APP_SIZE);
  localparam logic [AW-1:0] LDR_LO  = AW'(LDR_BASE);
  localparam logic [AW-1:0] LDR_END = AW'(LDR_BASE + LDR_SIZE);
  localparam logic [AW-1:0] CFG_LO  = AW'(CFG_BASE);
  localparam logic [AW-1:0] CFG_END = AW'(CFG_BASE + CFG_SIZE);

  fsm_e   state, stateNxt;
  fl_op_e opKind;
  logic   cmdKnown, isWrite, aligned;
  logic   inApp, inLdr, inCfg, inData, regionOk, refuse;

  always_comb begin
    cmdKnown = 1'b1;
    opKind   = FOP_READ;
    unique case (cmdCode)
      CMD_READ:  opKind = FOP_READ;
      CMD_PROG:  opKind = FOP_PROG;
      CMD_ERASE: opKind = FOP_ERASE;
      default:   cmdKnown = 1'b0;
    endcase
  end

  assign isWrite = (opKind != FOP_READ);
  assign aligned = (opAddr[1:0] == 2'b00);
  assign inApp   = (opAddr < APP_END);
  assign inLdr   = (opAddr >= LDR_LO) && (opAddr < LDR_END);
  assign inCfg   = (opAddr >= CFG_LO) && (opAddr < CFG_END);
  assign inData  = inApp && (opAddr >= dataBase);

  // region and protection rules
  always_comb begin
    if (inCfg)
      regionOk = protBits.cfgUpdEn;
    else if (inLdr)
      regionOk = !isWrite || (!protBits.bootSel && protBits.ldrUpdEn);
    else if (inApp)
      regionOk = !isWrite || inData || protBits.bootSel || protBits.appWrEn;
    else
      regionOk = 1'b0;
  end

  assign refuse = !cmdKnown || !aligned || !regionOk || bodEvent;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    flReq    = 1'b0;
    unique case (state)
      ST_IDLE:  if (trigStart) stateNxt = ST_CHECK;
      ST_CHECK: begin
        if (refuse) begin
          strobe.failSet = 1'b1;
          strobe.trigClr = 1'b1;
          stateNxt       = ST_IDLE;
        end else begin
          stateNxt = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        flReq = 1'b1;
        if (flAck) begin
          strobe.trigClr   = 1'b1;
          strobe.rdCapture = (opKind == FOP_READ);
          stateNxt         = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign flOp = opKind;

  // R3: a request only exists while the start bit reads busy
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> trigBusy);

  // R3 / R11: request and address held until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flReq && !flAck) |=> (flReq && $stable(opAddr)));

  // R3: acknowledge ends the operation
  p_ack_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flReq && flAck) |=> (!flReq && !trigBusy));

  // R5: only aligned addresses reach the flash
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> (opAddr[1:0] == 2'b00));

  // R5: a refusal returns to idle without a request
  p_refuse_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && refuse) |=> (!flReq && !trigBusy));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int unsigned APP_SIZE = 32'h0000_8000,
  parameter int unsigned LDR_BASE = 32'h0010_0000,
  parameter int unsigned LDR_SIZE = 32'h0000_1000,
  parameter int unsigned CFG_BASE = 32'h0030_0000,
  parameter int unsigned CFG_SIZE = 32'h0000_0010
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          porN,
  input  logic          cfgBootBit,
  input  logic [AW-1:0] cfgDataBase,
  input  logic          bodEvent,
  input  logic          regWrEn,
  input  logic [2:0]    regIdx,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          flReq,
  output logic [1:0]    flOp,
  output logic [AW-1:0] flAddr,
  output logic [DW-1:0] flWrData,
  input  logic          flAck,
  input  logic [DW-1:0] flRdData
);

  logic             sysRstN;
  ctl_strobe_t      strobe;
  prot_bits_t       protBits;
  logic             trigBusy, trigStart;
  logic [CMD_W-1:0] cmdCode;
  logic [AW-1:0]    dataBase;

  assign sysRstN = rstN && porN;

  fpc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(sysRstN), .porN(porN),
    .cfgBootBit(cfgBootBit), .cfgDataBase(cfgDataBase),
    .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .flRdData(flRdData),
    .protBits(protBits), .trigBusy(trigBusy), .trigStart(trigStart),
    .cmdCode(cmdCode), .opAddr(flAddr), .opData(flWrData),
    .dataBase(dataBase)
  );

  fpc_control #(
    .AW(AW), .APP_SIZE(APP_SIZE), .LDR_BASE(LDR_BASE), .LDR_SIZE(LDR_SIZE),
    .CFG_BASE(CFG_BASE), .CFG_SIZE(CFG_SIZE)
  ) u_ctl (
    .clk(clk), .rstN(sysRstN), .trigStart(trigStart), .trigBusy(trigBusy),
    .protBits(protBits), .cmdCode(cmdCode), .opAddr(flAddr),
    .dataBase(dataBase), .bodEvent(bodEvent), .flAck(flAck),
    .strobe(strobe), .flReq(flReq), .flOp(flOp)
  );

endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, porN, cfgBootBit, bodEvent, regWrEn, flAck, flReq;
  logic [2:0]  regIdx;
  logic [1:0]  flOp;
  logic [31:0] cfgDataBase, regWrData, regRdData, flAddr, flWrData, flRdData;

  flash_prog_ctrl u0 (
    .clk(clk), .rstN(rstN), .porN(porN), .cfgBootBit(cfgBootBit),
    .cfgDataBase(cfgDataBase), .bodEvent(bodEvent), .regWrEn(regWrEn),
    .regIdx(regIdx), .regWrData(regWrData), .regRdData(regRdData),
    .flReq(flReq), .flOp(flOp), .flAddr(flAddr), .flWrData(flWrData),
    .flAck(flAck), .flRdData(flRdData)
  );

  int    compared = 0, mismatched = 0;
  string curReq = "R1";
  bit    done = 0;

  // ---------------- behavioural reference model ----------------
  bit          mIsp, mBoot, mAppW, mCfgU, mLdrU, mFail, mTrig;
  logic [5:0]  mCmd;
  logic [31:0] mAddr, mData, mBase;
  int          mPh;  // 0 idle, 1 checking, 2 requesting
  bit          setF, clrT, isWr;

  function automatic bit allowed();
    bit wr;
    wr = (mCmd == 6'h21) || (mCmd == 6'h22);
    if (!(mCmd == 6'h00 || wr)) return 0;
    if (mAddr[1:0] != 2'b00) return 0;
    if (bodEvent) return 0;
    if (mAddr >= 32'h0030_0000 && mAddr < 32'h0030_0010) return mCfgU;
    if (mAddr >= 32'h0010_0000 && mAddr < 32'h0010_1000) return !wr || (!mBoot && mLdrU);
    if (mAddr < 32'h0000_8000) return !wr || (mAddr >= mBase) || mBoot || mAppW;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!porN) mBoot = !cfgBootBit;
    else if (regWrEn && regIdx == 3'd0) mBoot = regWrData[1];
    if (!(rstN && porN)) begin
      mIsp = 0; mAppW = 0; mCfgU = 0; mLdrU = 0; mFail = 0; mTrig = 0;
      mCmd = '0; mAddr = '0; mData = '0; mBase = cfgDataBase; mPh = 0;
    end else begin
      setF = 0; clrT = 0;
      if (mPh == 1) begin
        if (allowed()) mPh = 2;
        else begin setF = 1; clrT = 1; mPh = 0; end
      end else if (mPh == 2 && flAck) begin
        clrT = 1;
        if (mCmd == 6'h00) mData = flRdData;
        mPh = 0;
      end
      if (!mTrig && regWrEn) begin
        if (regIdx == 3'd2) mCmd  = regWrData[5:0];
        if (regIdx == 3'd3) mAddr = regWrData;
        if (regIdx == 3'd4) mData = regWrData;
      end
      if (setF) mFail = 1;
      else if (regWrEn && regIdx == 3'd0 && regWrData[6]) mFail = 0;
      if (regWrEn && regIdx == 3'd1 && regWrData[0] && mIsp && !mTrig) begin
        mTrig = 1; mPh = 1;
      end else if (clrT) mTrig = 0;
      if (regWrEn && regIdx == 3'd0) begin
        mIsp = regWrData[0]; mAppW = regWrData[3];
        mCfgU = regWrData[4]; mLdrU = regWrData[5];
      end
    end
  end

  function automatic logic [31:0] view(input logic [2:0] w);
    case (w)
      3'd0: return {25'b0, mFail, mLdrU, mCfgU, mAppW, 1'b0, mBoot, mIsp};
      3'd1: return {31'b0, mTrig};
      3'd2: return {26'b0, mCmd};
      3'd3: return mAddr;
      3'd4: return mData;
      3'd5: return mBase;
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- flash responder ----------------
  logic [31:0] mem [int unsigned];
  int lat = 0;
  always @(negedge clk) begin
    if (flAck === 1'b1) flAck = 1'b0;
    else if (flReq === 1'b1) begin
      lat++;
      if (lat >= 3) begin
        lat = 0;
        flAck = 1'b1;
        case (flOp)
          2'd0: flRdData = mem.exists(flAddr) ? mem[flAddr] : 32'hFFFF_FFFF;
          2'd1: mem[flAddr] = flWrData;
          default: mem[flAddr] = 32'hFFFF_FFFF;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [1:0] eOp;
    eOp = (mCmd == 6'h00) ? 2'd0 : (mCmd == 6'h21) ? 2'd1 : 2'd2;
    chk(flReq === (mPh == 2), "flReq", {31'b0, flReq}, {31'b0, (mPh == 2)});
    if (mPh == 2) begin
      chk(flAddr === mAddr, "flAddr", flAddr, mAddr);
      chk(flOp === eOp, "flOp", {30'b0, flOp}, {30'b0, eOp});
      chk(flWrData === mData, "flWrData", flWrData, mData);
    end
    chk(regRdData === view(regIdx), "readback", regRdData, view(regIdx));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    regWrEn = 1'b1; regIdx = idx; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic waitDone();
    int k;
    k = 0;
    while ((mTrig || mPh != 0) && k < 40) begin step(); k++; end
    step();
  endtask

  task automatic runOp(input logic [5:0] cmd, input logic [31:0] a, input logic [31:0] d);
    wr(3'd2, {26'b0, cmd});
    wr(3'd3, a);
    wr(3'd4, d);
    wr(3'd1, 32'h1);
    waitDone();
  endtask

  task automatic expectReg(input logic [2:0] idx, input logic [31:0] e, input string req);
    regIdx = idx;
    step();
    compared++;
    if (regRdData !== e) begin
      mismatched++;
      $display("FAIL %s register %0d: actual %h expected %h", req, idx, regRdData, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; porN = 0; cfgBootBit = 1; cfgDataBase = 32'h6000; bodEvent = 0;
    regWrEn = 0; regIdx = 0; regWrData = 0; flAck = 0; flRdData = 0;
    repeat (3) @(negedge clk);
    rstN = 1; porN = 1;

    curReq = "R1";
    for (int w = 0; w < 8; w++) begin regIdx = 3'(w); step(); end
    expectReg(3'd0, 32'h0, "R1");
    expectReg(3'd1, 32'h0, "R1");
    curReq = "R12";
    expectReg(3'd5, 32'h6000, "R12");

    curReq = "R2";
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1);
    repeat (3) step();
    expectReg(3'd1, 32'h0, "R2");

    curReq = "R9";
    wr(3'd0, 32'h1);
    runOp(6'h21, 32'h6000, 32'h1234_5678);
    expectReg(3'd0, 32'h1, "R9");

    curReq = "R3";
    wr(3'd2, 32'h21); wr(3'd3, 32'h6004); wr(3'd4, 32'hA5A5_0F0F); wr(3'd1, 32'h1);
    expectReg(3'd1, 32'h1, "R3");
    waitDone();
    expectReg(3'd1, 32'h0, "R3");

    curReq = "R4";
    runOp(6'h00, 32'h6000, 32'h0);
    expectReg(3'd4, 32'h1234_5678, "R4");

    curReq = "R13";
    runOp(6'h22, 32'h6000, 32'h0);
    runOp(6'h00, 32'h6000, 32'h0);
    expectReg(3'd4, 32'hFFFF_FFFF, "R13");
    runOp(6'h00, 32'h6004, 32'h0);
    expectReg(3'd4, 32'hA5A5_0F0F, "R13");

    curReq = "R6";
    runOp(6'h21, 32'h100, 32'h11);
    expectReg(3'd0, 32'h41, "R6");
    curReq = "R10";
    wr(3'd0, 32'h01);
    expectReg(3'd0, 32'h41, "R10");
    wr(3'd0, 32'h41);
    expectReg(3'd0, 32'h01, "R10");
    curReq = "R6";
    wr(3'd0, 32'h09);
    runOp(6'h21, 32'h100, 32'h22);
    expectReg(3'd0, 32'h09, "R6");
    runOp(6'h00, 32'h100, 32'h0);
    expectReg(3'd4, 32'h22, "R6");

    curReq = "R5";
    runOp(6'h21, 32'h6002, 32'h1);
    expectReg(3'd0, 32'h49, "R5"); wr(3'd0, 32'h49);
    runOp(6'h21, 32'h9000, 32'h1);
    expectReg(3'd0, 32'h49, "R5"); wr(3'd0, 32'h49);
    runOp(6'h05, 32'h6000, 32'h1);
    expectReg(3'd0, 32'h49, "R5"); wr(3'd0, 32'h49);
    bodEvent = 1;
    runOp(6'h00, 32'h6000, 32'h1);
    bodEvent = 0;
    expectReg(3'd0, 32'h49, "R5"); wr(3'd0, 32'h49);
    expectReg(3'd0, 32'h09, "R5");

    curReq = "R7";
    runOp(6'h21, 32'h0010_0000, 32'h5);
    expectReg(3'd0, 32'h49, "R7"); wr(3'd0, 32'h49);
    wr(3'd0, 32'h29);
    runOp(6'h21, 32'h0010_0000, 32'h5);
    expectReg(3'd0, 32'h29, "R7");

    curReq = "R8";
    runOp(6'h00, 32'h0030_0000, 32'h0);
    expectReg(3'd0, 32'h69, "R8"); wr(3'd0, 32'h69);
    wr(3'd0, 32'h39);
    runOp(6'h00, 32'h0030_0000, 32'h0);
    expectReg(3'd0, 32'h39, "R8");
    expectReg(3'd4, 32'hFFFF_FFFF, "R8");

    curReq = "R11";
    wr(3'd2, 32'h21); wr(3'd3, 32'h6010); wr(3'd4, 32'hCAFE_0001); wr(3'd1, 32'h1);
    wr(3'd3, 32'h6020); wr(3'd4, 32'h0000_DEAD); wr(3'd2, 32'h00);
    waitDone();
    expectReg(3'd3, 32'h6010, "R11");
    expectReg(3'd2, 32'h21, "R11");
    runOp(6'h00, 32'h6010, 32'h0);
    expectReg(3'd4, 32'hCAFE_0001, "R11");

    curReq = "R6";
    wr(3'd0, 32'h3B);
    runOp(6'h21, 32'h0010_0000, 32'h7);
    expectReg(3'd0, 32'h7B, "R6"); wr(3'd0, 32'h7B);
    wr(3'd0, 32'h33);
    runOp(6'h21, 32'h104, 32'h9);
    expectReg(3'd0, 32'h33, "R6");

    curReq = "R12";
    cfgDataBase = 32'h7000;
    rstN = 0; step(); step(); rstN = 1;
    expectReg(3'd0, 32'h02, "R12");
    expectReg(3'd5, 32'h7000, "R12");
    wr(3'd5, 32'h1234);
    expectReg(3'd5, 32'h7000, "R12");
    porN = 0; step(); porN = 1;
    expectReg(3'd0, 32'h00, "R12");

    repeat (3) step();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule